// File: doc/BRIEF.md
# Prefetch Holding Queue with Selectable Ordering and Overflow Policy

This block holds prefetch requests, each a DRAM bank, row and column, until the memory scheduler issues them. Requests are kept in age order. A static pair of mode inputs chooses how the issue point is picked: the youngest entry (stack order) or the oldest entry (queue order). The same inputs choose what happens when a request arrives and every slot is taken. In one policy the arrival is thrown away. In the other the oldest stored request is discarded to make room for it.

A second read path lets the scheduler use an open DRAM row. It presents a bank and row. The block reports the youngest stored request that targets that row, together with its column. If the scheduler takes that request, it is removed from wherever it sits, and the entries younger than it close the gap while keeping their relative age. The count of stored entries and full and empty flags are always visible.

Top module: `pf_order_queue`

## Requirements
- R1: While reset is asserted and after its release, the queue is empty: `count` is 0, `empty` is 1, `full` is 0 and `head_valid` is 0.
- R2: `count` equals the number of stored requests, which is at most DEPTH (default 128). `full` is 1 exactly when `count` equals DEPTH. `empty` is 1 exactly when `count` is 0. `count` changes by at most one per cycle.
- R3: With `ord_newest_first`=1, the head outputs show the most recently accepted request that is still stored.
- R4: With `ord_newest_first`=0, the head outputs show the oldest stored request.
- R5: With `full_evicts`=1, a push into a full queue with no removal in the same cycle discards the oldest request and stores the new one as the youngest. `count` stays at DEPTH.
- R6: With `full_evicts`=0, a push into a full queue with no removal in the same cycle is discarded, and the stored contents are left unchanged.
- R7: `look_hit` is 1 when a stored request matches both `look_bank` and `look_row`. `look_col` is then the column of the youngest such request. Nothing else is reported as a hit.
- R8: `look_take` with `look_hit`=1 removes the reported request. All other requests keep their relative age order.
- R9: When `look_take` produces a hit in the same cycle as `pop_req`, only the looked-up request is removed, and the pop has no effect.
- R10: A push together with a removal in the same cycle performs both, and `count` does not change. This holds even when the queue is full, and in that case nothing is evicted.
- R11: `pop_req` on an empty queue removes nothing. A push in the same cycle is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ord_newest_first | input | 1 | 1: head is the youngest entry; 0: head is the oldest entry |
| full_evicts | input | 1 | 1: a push into a full queue evicts the oldest entry; 0: the push is dropped |
| push_valid | input | 1 | Offer a new request |
| push_bank | input | BANK_W | Bank of the new request |
| push_row | input | ROW_W | Row of the new request |
| push_col | input | COL_W | Column of the new request |
| pop_req | input | 1 | Remove the head entry |
| head_valid | output | 1 | Head outputs hold a stored entry |
| head_bank | output | BANK_W | Bank of the head entry |
| head_row | output | ROW_W | Row of the head entry |
| head_col | output | COL_W | Column of the head entry |
| look_bank | input | BANK_W | Bank of the open row to search for |
| look_row | input | ROW_W | Row to search for |
| look_take | input | 1 | Remove the entry reported by the search |
| look_hit | output | 1 | A stored entry matches the search |
| look_col | output | COL_W | Column of the youngest matching entry |
| full | output | 1 | DEPTH entries stored |
| empty | output | 1 | No entries stored |
| count | output | $clog2(DEPTH+1) | Number of stored entries |

## Verification
The bench uses a small queue and a narrow bank and row space. This fills the queue often and makes it common for several entries to share a row. It then switches among all four mode combinations and varies how often requests are pushed. The bench checks the following cases:
- Eviction. A design that evicted from the wrong end would lose young requests, and the error would appear at the head in stack order.
- Drop policy. A design whose drop policy still wrote the full queue would change its contents silently.
- Lookup order. A lookup that returned the oldest match, or a stale slot above `count`, would report the wrong column.
- Middle removal. A removal from the middle that did not compact the queue correctly would leave a hole or duplicate an entry, and every later head and lookup would diverge.
- Simultaneous push and removal. When the queue is full, a push together with a removal must not also evict. A design that did would drop a request.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  // Source of the single removal allowed per cycle
  typedef enum logic [1:0] {
    RM_NONE  = 2'd0,
    RM_HEAD  = 2'd1,
    RM_MATCH = 2'd2,
    RM_EVICT = 2'd3
  } rm_kind_t;

endpackage

// File: rtl/pfq_match_finder.sv
module pfq_match_finder #(
  parameter int DEPTH = 128,
  parameter int KEY_W = 17,
  parameter int IDX_W = 7
) (
  input  logic [DEPTH-1:0][KEY_W-1:0] keys,
  input  logic [DEPTH-1:0]            live,
  input  logic [KEY_W-1:0]            probe,
  output logic                        hit,
  output logic [IDX_W-1:0]            idx
);

  logic [DEPTH-1:0] eq;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign eq[i] = live[i] && (keys[i] == probe);
  end

  // Slots are age ordered, so the highest matching index is the youngest
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (eq[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/pfq_ctrl.sv
module pfq_ctrl
  import pfq_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int CNT_W = 8,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ord_newest_first,
  input  logic             full_evicts,
  input  logic             push_valid,
  input  logic             pop_req,
  input  logic             look_take,
  input  logic             look_hit,
  input  logic [IDX_W-1:0] look_idx,
  output logic [CNT_W-1:0] count,
  output logic [IDX_W-1:0] head_idx,
  output logic [DEPTH-1:0] live,
  output logic             rm_en,
  output logic [IDX_W-1:0] rm_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  rm_kind_t         rm_kind;
  logic             has_entries;
  logic             is_full;
  logic [CNT_W-1:0] cnt_after_rm;
  logic [CNT_W-1:0] cnt_next;
  logic             cnt_en;

  assign has_entries = (count != '0);
  assign is_full     = (count == DEPTH_C);

  // Head slot: youngest (top of occupied range) or oldest (slot 0)
  always_comb begin
    if (ord_newest_first && has_entries) head_idx = IDX_W'(count - 1'b1);
    else                                 head_idx = '0;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_live
    assign live[i] = (CNT_W'(i) < count);
  end

  // Removal arbitration: lookup take over pop over eviction
  always_comb begin
    rm_kind = RM_NONE;
    if (look_take && look_hit)                     rm_kind = RM_MATCH;
    else if (pop_req && has_entries)               rm_kind = RM_HEAD;
    else if (push_valid && is_full && full_evicts) rm_kind = RM_EVICT;
  end

  always_comb begin
    unique case (rm_kind)
      RM_MATCH: rm_idx = look_idx;
      RM_HEAD:  rm_idx = head_idx;
      default:  rm_idx = '0;
    endcase
  end

  assign rm_en        = (rm_kind != RM_NONE);
  assign cnt_after_rm = count - CNT_W'(rm_en);
  assign wr_en        = push_valid && (cnt_after_rm < DEPTH_C);
  assign wr_idx       = IDX_W'(cnt_after_rm);

  // Next-state for the occupancy counter
  always_comb begin
    cnt_next = cnt_after_rm + CNT_W'(wr_en);
    cnt_en   = rm_en || wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (cnt_en) count <= cnt_next;
  end

endmodule

// File: rtl/pfq_store.sv
module pfq_store #(
  parameter int DEPTH = 128,
  parameter int ENT_W = 24,
  parameter int IDX_W = 7
) (
  input  logic                        clk,
  input  logic                        rm_en,
  input  logic [IDX_W-1:0]            rm_idx,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [ENT_W-1:0]            wr_data,
  output logic [DEPTH-1:0][ENT_W-1:0] slots
);

  // Slot 0 is the oldest entry; removal shifts everything above it down one
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic             slot_en;
    logic [ENT_W-1:0] slot_nxt;
    logic             shift_in;

    if (i < DEPTH - 1) begin : g_shift
      assign shift_in = rm_en && (IDX_W'(i) >= rm_idx);
    end else begin : g_top
      assign shift_in = 1'b0;
    end

    always_comb begin
      slot_en  = 1'b0;
      slot_nxt = slots[i];
      if (wr_en && (wr_idx == IDX_W'(i))) begin
        slot_en  = 1'b1;
        slot_nxt = wr_data;
      end else if (shift_in) begin
        slot_en  = 1'b1;
        slot_nxt = slots[(i + 1) % DEPTH];
      end
    end

    always_ff @(posedge clk) begin
      if (slot_en) slots[i] <= slot_nxt;
    end
  end

endmodule

// File: rtl/pf_order_queue.sv
module pf_order_queue #(
  parameter int DEPTH  = 128,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 7,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ord_newest_first,
  input  logic              full_evicts,
  input  logic              push_valid,
  input  logic [BANK_W-1:0] push_bank,
  input  logic [ROW_W-1:0]  push_row,
  input  logic [COL_W-1:0]  push_col,
  input  logic              pop_req,
  output logic              head_valid,
  output logic [BANK_W-1:0] head_bank,
  output logic [ROW_W-1:0]  head_row,
  output logic [COL_W-1:0]  head_col,
  input  logic [BANK_W-1:0] look_bank,
  input  logic [ROW_W-1:0]  look_row,
  input  logic              look_take,
  output logic              look_hit,
  output logic [COL_W-1:0]  look_col,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  count
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int KEY_W = BANK_W + ROW_W;
  localparam int ENT_W = KEY_W + COL_W;

  logic [DEPTH-1:0][ENT_W-1:0] slots;
  logic [DEPTH-1:0][KEY_W-1:0] keys;
  logic [DEPTH-1:0]            live;
  logic [IDX_W-1:0]            head_idx;
  logic [IDX_W-1:0]            look_idx;
  logic                        rm_en;
  logic [IDX_W-1:0]            rm_idx;
  logic                        wr_en;
  logic [IDX_W-1:0]            wr_idx;
  logic [ENT_W-1:0]            head_ent;
  logic [ENT_W-1:0]            look_ent;

  for (genvar i = 0; i < DEPTH; i++) begin : g_key
    assign keys[i] = slots[i][ENT_W-1:COL_W];
  end

  pfq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctrl (
    .clk              (clk),
    .rst_n            (rst_n),
    .ord_newest_first (ord_newest_first),
    .full_evicts      (full_evicts),
    .push_valid       (push_valid),
    .pop_req          (pop_req),
    .look_take        (look_take),
    .look_hit         (look_hit),
    .look_idx         (look_idx),
    .count            (count),
    .head_idx         (head_idx),
    .live             (live),
    .rm_en            (rm_en),
    .rm_idx           (rm_idx),
    .wr_en            (wr_en),
    .wr_idx           (wr_idx)
  );

  pfq_store #(.DEPTH(DEPTH), .ENT_W(ENT_W), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .rm_en   (rm_en),
    .rm_idx  (rm_idx),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data ({push_bank, push_row, push_col}),
    .slots   (slots)
  );

  pfq_match_finder #(.DEPTH(DEPTH), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_find (
    .keys  (keys),
    .live  (live),
    .probe ({look_bank, look_row}),
    .hit   (look_hit),
    .idx   (look_idx)
  );

  assign head_ent   = slots[head_idx];
  assign look_ent   = slots[look_idx];
  assign head_valid = (count != '0);
  assign empty      = (count == '0);
  assign full       = (count == CNT_W'(DEPTH));
  assign head_bank  = head_ent[ENT_W-1:KEY_W - BANK_W + COL_W];
  assign head_row   = head_ent[COL_W + ROW_W - 1:COL_W];
  assign head_col   = head_ent[COL_W-1:0];
  assign look_col   = look_ent[COL_W-1:0];

endmodule

// File: rtl/pf_order_queue_chk.sv
module pf_order_queue_chk #(
  parameter int DEPTH  = 128,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ord_newest_first,
  input logic              full_evicts,
  input logic              push_valid,
  input logic [BANK_W-1:0] push_bank,
  input logic [ROW_W-1:0]  push_row,
  input logic              pop_req,
  input logic              look_take,
  input logic              look_hit,
  input logic [BANK_W-1:0] head_bank,
  input logic [ROW_W-1:0]  head_row,
  input logic              full,
  input logic              empty,
  input logic [CNT_W-1:0]  count
);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (count == $past(count)) || (count == $past(count) + 1'b1) || (count + 1'b1 == $past(count))); // R2

  AST_EVICT_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    full && full_evicts && push_valid && !pop_req && !look_take |=> full); // R5

  AST_DROP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    full && !full_evicts && push_valid && !pop_req && !look_take |=> full && $stable(count)); // R6

  AST_NEWEST_AT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    ord_newest_first && push_valid && !full && !pop_req && !look_take |=>
      !ord_newest_first || (head_bank == $past(push_bank) && head_row == $past(push_row))); // R3

  AST_TAKE_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    look_take && look_hit && !push_valid |=> count + 1'b1 == $past(count)); // R8

  AST_PAIR_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !empty && push_valid && pop_req |=> $stable(count)); // R10

  AST_EMPTY_POP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    empty && !push_valid |=> empty); // R11

endmodule

bind pf_order_queue pf_order_queue_chk #(
  .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .CNT_W(CNT_W)
) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .ord_newest_first (ord_newest_first),
  .full_evicts      (full_evicts),
  .push_valid       (push_valid),
  .push_bank        (push_bank),
  .push_row         (push_row),
  .pop_req          (pop_req),
  .look_take        (look_take),
  .look_hit         (look_hit),
  .head_bank        (head_bank),
  .head_row         (head_row),
  .full             (full),
  .empty            (empty),
  .count            (count)
);

// File: tb/pf_order_queue_test.sv
module pf_order_queue_test;

  localparam int DEPTH  = 8;
  localparam int BANK_W = 2;
  localparam int ROW_W  = 3;
  localparam int COL_W  = 4;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ord_newest_first, full_evicts;
  logic              push_valid, pop_req, look_take;
  logic [BANK_W-1:0] push_bank, look_bank, head_bank;
  logic [ROW_W-1:0]  push_row, look_row, head_row;
  logic [COL_W-1:0]  push_col, head_col, look_col;
  logic              head_valid, look_hit, full, empty;
  logic [CNT_W-1:0]  count;

  int n_chk = 0;
  int n_fail = 0;
  int mq[$];          // model contents, index 0 oldest; entry = bank<<8 | row<<4 | col
  string ctx = "";

  always #10 clk = ~clk;   // 50 MHz

  pf_order_queue #(.DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) uut (
    .clk(clk), .rst_n(rst_n), .ord_newest_first(ord_newest_first), .full_evicts(full_evicts),
    .push_valid(push_valid), .push_bank(push_bank), .push_row(push_row), .push_col(push_col),
    .pop_req(pop_req), .head_valid(head_valid), .head_bank(head_bank), .head_row(head_row),
    .head_col(head_col), .look_bank(look_bank), .look_row(look_row), .look_take(look_take),
    .look_hit(look_hit), .look_col(look_col), .full(full), .empty(empty), .count(count)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", what, ctx, act, exp);
    end
  endtask

  function automatic int key_of(input int e);
    return e >> 4;
  endfunction

  // Index of youngest model entry matching the lookup key, -1 if none
  function automatic int find_young(input int key);
    int r = -1;
    for (int i = 0; i < mq.size(); i++) if (key_of(mq[i]) == key) r = i;
    return r;
  endfunction

  task automatic compare_outputs();
    int sz = mq.size();
    int hd;
    int lk = find_young((int'(look_bank) << 4) | int'(look_row));
    chk(int'(count) == sz, "R2 count", int'(count), sz);
    chk(full == (sz == DEPTH), "R2 full", int'(full), int'(sz == DEPTH));
    chk(empty == (sz == 0), "R2 empty", int'(empty), int'(sz == 0));
    chk(head_valid == (sz != 0), "R2 head_valid", int'(head_valid), int'(sz != 0));
    if (sz != 0) begin
      hd = ord_newest_first ? mq[sz-1] : mq[0];
      chk(((int'(head_bank) << 8) | (int'(head_row) << 4) | int'(head_col)) == hd,
          ord_newest_first ? "R3 head newest" : "R4 head oldest",
          (int'(head_bank) << 8) | (int'(head_row) << 4) | int'(head_col), hd);
    end
    chk(look_hit == (lk >= 0), "R7 look_hit", int'(look_hit), int'(lk >= 0));
    if (lk >= 0) chk(int'(look_col) == (mq[lk] & 15), "R7 look_col", int'(look_col), mq[lk] & 15);
  endtask

  task automatic model_step();
    int lk = find_young((int'(look_bank) << 4) | int'(look_row));
    bit take_hit = look_take && (lk >= 0);
    bit pop_ok = pop_req && (mq.size() != 0) && !take_hit;
    bit was_full = (mq.size() == DEPTH);
    ctx = "";
    if (take_hit) begin
      mq.delete(lk);
      ctx = pop_req ? "after R9 take-over-pop" : "after R8 middle take";
    end else if (pop_ok) begin
      if (ord_newest_first) void'(mq.pop_back()); else void'(mq.pop_front());
    end else if (pop_req) ctx = "after R11 empty pop";
    if (push_valid) begin
      if (was_full && !take_hit && !pop_ok) begin
        if (full_evicts) begin
          void'(mq.pop_front());
          ctx = "after R5 evict";
        end else ctx = "after R6 drop";
      end else if (take_hit || pop_ok) ctx = "after R10 push+remove";
      if (mq.size() < DEPTH)
        mq.push_back((int'(push_bank) << 8) | (int'(push_row) << 4) | int'(push_col));
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0;
    ord_newest_first = 1'b1; full_evicts = 1'b1;
    push_valid = 1'b0; pop_req = 1'b0; look_take = 1'b0;
    push_bank = '0; push_row = '0; push_col = '0; look_bank = '0; look_row = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(int'(count) == 0 && empty && !full && !head_valid, "R1 reset state", int'(count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(int'(count) == 0 && empty && !head_valid, "R1 after release", int'(count), 0);
    for (int ph = 0; ph < 12; ph++) begin
      for (int cyc = 0; cyc < 500; cyc++) begin
        @(negedge clk);
        ord_newest_first = ph[0];
        full_evicts      = ph[1];
        push_valid = ($urandom_range(99) < ((ph >= 4 && ph < 8) ? 85 : 45));
        push_bank  = BANK_W'($urandom);
        push_row   = ROW_W'($urandom_range(2));
        push_col   = COL_W'($urandom);
        pop_req    = ($urandom_range(99) < 25);
        look_take  = ($urandom_range(99) < 20);
        if (mq.size() != 0 && $urandom_range(1) == 1) begin
          int e = mq[$urandom_range(mq.size() - 1)];
          look_bank = BANK_W'(e >> 8);
          look_row  = ROW_W'(e >> 4);
        end else begin
          look_bank = BANK_W'($urandom);
          look_row  = ROW_W'($urandom_range(2));
        end
        #1;
        compare_outputs();
        model_step();
      end
    end
    @(negedge clk);
    push_valid = 1'b0; pop_req = 1'b0; look_take = 1'b0;
    #1;
    compare_outputs();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule